// File: doc/BRIEF.md
# Interrupt Vector Fetch and Dispatch Unit

This unit turns a pending maskable interrupt request into a jump target for the CPU. A request is taken only at an instruction boundary and only while the global interrupt mask is clear. Once taken, the unit sets the mask and issues one push strobe per byte of the saved register frame. It then reads the two-byte vector for the requesting source from memory, high byte first, and presents the assembled target as a one-cycle jump pulse.

Two vector tables are supported. The standard table sits at the top of the address space. The relocated table sits in RAM and is selected by a mode input. An entry of zero in the relocated table is treated as an unset vector: the unit raises a trap/restart pulse in place of the jump. The mask stays set until the CPU signals a return from the service routine.

Top module: `irq_dispatch`

## Requirements
- R1: A request is accepted only in a cycle where `irq_req_i` and `insn_done_i` are both high, the mask is clear and the unit is idle. A boundary strobe with no request, or a request with no boundary strobe, starts nothing.
- R2: Acceptance sets `mask_o` from the next cycle onward. While the mask is set, further requests and boundary strobes are ignored. A `rti_i` pulse while idle clears the mask.
- R3: After acceptance, `push_o` is high for exactly 9 consecutive cycles. No memory read occurs before or during these cycles.
- R4: In standard mode (`alt_tbl_i`=0) the vector of source `s` is read at 0xFFF2-2*s (high byte) and then at the next address (low byte). The two reads occur on consecutive cycles right after the last push. Source 0 is the external request at 0xFFF2/0xFFF3.
- R5: In relocated mode (`alt_tbl_i`=1) each vector address is the standard address minus 0xF000. For example, source 0 reads 0x0FF2/0x0FF3, and all entries fall within 0x0F8A–0x0FFF.
- R6: Memory returns `mem_data_i` one cycle after the read cycle. The target is {high byte, low byte}. `jump_valid_o` is high for exactly one cycle, two cycles after the low-byte read cycle, with the target on `jump_addr_o`.
- R7: In relocated mode a fetched vector of 0x0000 gives a one-cycle `trap_o` pulse in place of `jump_valid_o`. The mask stays set.
- R8: A nonzero vector in relocated mode, and any vector in standard mode (zero included), gives a jump with `trap_o` low.
- R9: After reset the mask is clear and `push_o`, `mem_rd_o`, `jump_valid_o` and `trap_o` are low.
- R10: Source and table mode are captured at acceptance. Changes on `irq_src_i` or `alt_tbl_i` during the sequence do not alter the addresses read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 1 | Maskable interrupt request level |
| irq_src_i | input | 3 | Index of the requesting source |
| insn_done_i | input | 1 | Instruction boundary strobe |
| alt_tbl_i | input | 1 | 1 selects the relocated RAM vector table |
| rti_i | input | 1 | Return-from-interrupt strobe, clears the mask |
| push_o | output | 1 | One strobe per stacked register byte |
| mem_rd_o | output | 1 | Vector byte read request |
| mem_addr_o | output | 16 | Vector byte address |
| mem_data_i | input | 8 | Read data, one cycle after the request |
| jump_valid_o | output | 1 | One-cycle pulse: jump target valid |
| jump_addr_o | output | 16 | Service routine address |
| trap_o | output | 1 | One-cycle pulse: empty relocated vector |
| mask_o | output | 1 | Global interrupt mask |

## Verification
The bench starts each scenario by holding a request with no boundary strobe, and checks that no push begins; a unit that ignored the boundary would push early. It counts pushes and read addresses cycle by cycle. A swapped byte order, a wrong table offset or a read overlapping the push frame therefore shows up as a wrong address or a wrong jump value. The bench separates a zero vector in the relocated table, which must trap, from a zero vector in the standard table, which must jump to 0x0000. It also toggles source and mode in the middle of a sequence, so a design that does not latch them reads the wrong entry.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_RD_HI,
    ST_RD_LO,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned SRC_W      = 3,
  parameter logic [15:0] VEC_TOP    = 16'hFFF2,
  parameter logic [15:0] ALT_OFFSET = 16'hF000
) (
  input  logic [SRC_W-1:0]  src_i,
  input  logic              alt_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] std_addr;
  logic [ADDR_W-1:0] src_off;

  always_comb begin
    src_off  = ADDR_W'(src_i) << 1;
    std_addr = ADDR_W'(VEC_TOP) - src_off;
    addr_o   = alt_i ? (std_addr - ADDR_W'(ALT_OFFSET)) : std_addr;
  end
endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic mask_o
);
  logic mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= 1'b0;
    else if (set_i)  mask_q <= 1'b1;
    else if (clr_i)  mask_q <= 1'b0;
  end

  assign mask_o = mask_q;

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> mask_o); // R2
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_dispatch_pkg::*;
#(
  parameter int unsigned PUSH_BYTES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  output logic idle_o,
  output logic push_o,
  output logic rd_hi_o,
  output logic rd_lo_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (PUSH_BYTES > 1) ? $clog2(PUSH_BYTES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PUSH_BYTES - 1);

  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:  if (accept_i) begin
                  state_d = ST_PUSH;
                  cnt_d   = '0;
                end
      ST_PUSH:  if (cnt_q == CNT_LAST) state_d = ST_RD_HI;
                else cnt_d = cnt_q + 1'b1;
      ST_RD_HI: state_d = ST_RD_LO;
      ST_RD_LO: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign idle_o  = (state_q == ST_IDLE);
  assign push_o  = (state_q == ST_PUSH);
  assign rd_hi_o = (state_q == ST_RD_HI);
  assign rd_lo_o = (state_q == ST_RD_LO);
  assign done_o  = (state_q == ST_DONE);

  AST_HI_AFTER_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi_o |-> $past(push_o)); // R3
  AST_PUSH_FROM_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(push_o) |-> $past(accept_i)); // R1
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned NUM_SRC    = 8,
  parameter int unsigned PUSH_BYTES = 9,
  parameter logic [15:0] VEC_TOP    = 16'hFFF2,
  parameter logic [15:0] ALT_OFFSET = 16'hF000,
  localparam int unsigned SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_req_i,
  input  logic [SRC_W-1:0]  irq_src_i,
  input  logic              insn_done_i,
  input  logic              alt_tbl_i,
  input  logic              rti_i,
  output logic              push_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              jump_valid_o,
  output logic [ADDR_W-1:0] jump_addr_o,
  output logic              trap_o,
  output logic              mask_o
);
  localparam int unsigned TGT_W = 2 * DATA_W;

  logic              idle, accept, rd_hi, rd_lo, done;
  logic [SRC_W-1:0]  src_q;
  logic              alt_q;
  logic [DATA_W-1:0] hi_q;
  logic [ADDR_W-1:0] vec_addr;
  logic [TGT_W-1:0]  target;
  logic              empty_vec;
  logic              jv_q, trap_q;
  logic [ADDR_W-1:0] jump_q;

  assign accept = idle && irq_req_i && insn_done_i && !mask_o;

  irq_mask_ctl u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (accept),
    .clr_i  (rti_i && idle),
    .mask_o (mask_o)
  );

  irq_seq_fsm #(.PUSH_BYTES(PUSH_BYTES)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .idle_o   (idle),
    .push_o   (push_o),
    .rd_hi_o  (rd_hi),
    .rd_lo_o  (rd_lo),
    .done_o   (done)
  );

  irq_vec_addr #(
    .ADDR_W(ADDR_W), .SRC_W(SRC_W), .VEC_TOP(VEC_TOP), .ALT_OFFSET(ALT_OFFSET)
  ) u_addr (
    .src_i  (src_q),
    .alt_i  (alt_q),
    .addr_o (vec_addr)
  );

  assign mem_rd_o   = rd_hi | rd_lo;
  assign mem_addr_o = vec_addr + ADDR_W'(rd_lo);

  // data of a read arrives one cycle later
  assign target    = {hi_q, mem_data_i};
  assign empty_vec = alt_q && (target == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      alt_q  <= 1'b0;
      hi_q   <= '0;
      jv_q   <= 1'b0;
      trap_q <= 1'b0;
      jump_q <= '0;
    end else begin
      if (accept) begin
        src_q <= irq_src_i;
        alt_q <= alt_tbl_i;
      end
      if (rd_lo) hi_q <= mem_data_i;
      jv_q   <= done && !empty_vec;
      trap_q <= done && empty_vec;
      if (done) jump_q <= ADDR_W'(target);
    end
  end

  assign jump_valid_o = jv_q;
  assign trap_o       = trap_q;
  assign jump_addr_o  = jump_q;

  AST_NO_READ_IN_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_o && mem_rd_o)); // R3
  AST_MASK_AT_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(push_o) |-> mask_o); // R2
  AST_LO_FOLLOWS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !mem_addr_o[0]) |=> (mem_rd_o && mem_addr_o == $past(mem_addr_o) + 1'b1)); // R4
  AST_ALT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && alt_q) |-> (mem_addr_o >= ADDR_W'(16'h0F8A) && mem_addr_o <= ADDR_W'(16'h0FFF))); // R5
  AST_JUMP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_valid_o |=> !jump_valid_o); // R6
  AST_TRAP_XOR_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(jump_valid_o && trap_o)); // R7
  AST_MASK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o && !idle) |=> mask_o); // R2
endmodule

// File: tb/irq_dispatch_test.sv
module irq_dispatch_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq_req_i = 1'b0;
  logic [2:0]  irq_src_i = '0;
  logic        insn_done_i = 1'b0;
  logic        alt_tbl_i = 1'b0;
  logic        rti_i = 1'b0;
  logic        push_o, mem_rd_o, jump_valid_o, trap_o, mask_o;
  logic [15:0] mem_addr_o, jump_addr_o;
  logic [7:0]  mem_data_i = '0;

  int checks = 0;
  int errors = 0;

  logic [7:0] tbl [logic [15:0]];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_dispatch uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_req_i(irq_req_i), .irq_src_i(irq_src_i),
    .insn_done_i(insn_done_i), .alt_tbl_i(alt_tbl_i), .rti_i(rti_i),
    .push_o(push_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mem_data_i(mem_data_i), .jump_valid_o(jump_valid_o), .jump_addr_o(jump_addr_o),
    .trap_o(trap_o), .mask_o(mask_o)
  );

  // memory with one cycle read latency
  always @(posedge clk_i)
    if (mem_rd_o) mem_data_i <= tbl.exists(mem_addr_o) ? tbl[mem_addr_o] : 8'h5A;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic do_rti();
    @(negedge clk_i); rti_i = 1'b1;
    @(negedge clk_i); rti_i = 1'b0;
    chk(mask_o == 1'b0, "R2 rti clears mask", mask_o, 0);
  endtask

  // full acceptance and dispatch; flip toggles src/mode mid-sequence
  task automatic run_irq(input logic [2:0] src, input logic alt, input bit flip,
                         input logic [15:0] exp_hi, input logic [15:0] exp_tgt,
                         input bit exp_trap, input string tag);
    int pushes = 0, reads = 0, bad_push = 0, bad_rd = 0, jv_at = -1, tr_at = -1;
    logic [15:0] got_tgt = '0;
    @(negedge clk_i);
    irq_src_i = src; alt_tbl_i = alt; irq_req_i = 1'b1;
    idle_cycles(3);
    chk(push_o == 1'b0 && mask_o == 1'b0, {"R1 wait for boundary ", tag}, push_o, 0);
    insn_done_i = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk_i);
      if (k == 1) begin
        insn_done_i = 1'b0; irq_req_i = 1'b0;
        chk(mask_o == 1'b1, {"R2 mask on accept ", tag}, mask_o, 1);
        if (flip) begin irq_src_i = ~src; alt_tbl_i = ~alt; end
      end
      if (push_o) begin pushes++; if (k > 9) bad_push++; end
      if (mem_rd_o) begin
        reads++;
        if (k == 10) begin if (mem_addr_o != exp_hi) bad_rd++; end
        else if (k == 11) begin if (mem_addr_o != exp_hi + 16'd1) bad_rd++; end
        else bad_rd++;
        if (k <= 9) bad_push++;
      end
      if (jump_valid_o) begin if (jv_at < 0) jv_at = k; got_tgt = jump_addr_o; end
      if (trap_o && tr_at < 0) tr_at = k;
    end
    chk(pushes == 9 && bad_push == 0, {"R3 push frame ", tag}, pushes, 9);
    chk(reads == 2 && bad_rd == 0, {"R4/R5/R10 vector addresses ", tag}, reads, 2);
    if (exp_trap) begin
      chk(tr_at == 13 && jv_at < 0, {"R7 trap on empty entry ", tag}, tr_at, 13);
    end else begin
      chk(jv_at == 13 && tr_at < 0, {"R6/R8 jump timing ", tag}, jv_at, 13);
      chk(got_tgt == exp_tgt, {"R6 jump target ", tag}, got_tgt, exp_tgt);
    end
    chk(mask_o == 1'b1, {"R2 mask held ", tag}, mask_o, 1);
    irq_src_i = '0; alt_tbl_i = 1'b0;
  endtask

  task automatic test_reset();
    chk(mask_o == 0 && push_o == 0 && mem_rd_o == 0 && jump_valid_o == 0 && trap_o == 0,
        "R9 reset state", {mask_o, push_o, mem_rd_o, jump_valid_o, trap_o}, 0);
  endtask

  task automatic test_strobe_only();
    int seen = 0;
    @(negedge clk_i); insn_done_i = 1'b1;
    for (int i = 0; i < 4; i++) begin @(negedge clk_i); if (push_o || mask_o) seen++; end
    insn_done_i = 1'b0;
    chk(seen == 0, "R1 strobe without request", seen, 0);
  endtask

  task automatic test_masked();
    int seen = 0;
    @(negedge clk_i); irq_req_i = 1'b1; insn_done_i = 1'b1;
    for (int i = 0; i < 6; i++) begin @(negedge clk_i); if (push_o || mem_rd_o) seen++; end
    irq_req_i = 1'b0; insn_done_i = 1'b0;
    chk(seen == 0, "R2 request ignored while masked", seen, 0);
  endtask

  initial begin
    tbl[16'hFFF2] = 8'h12; tbl[16'hFFF3] = 8'h34;
    tbl[16'hFFEC] = 8'hAB; tbl[16'hFFED] = 8'hCD;
    tbl[16'h0FF2] = 8'h08; tbl[16'h0FF3] = 8'h00;
    tbl[16'h0FEE] = 8'h00; tbl[16'h0FEF] = 8'h00;
    tbl[16'hFFE8] = 8'h00; tbl[16'hFFE9] = 8'h00;
    tbl[16'h0FE6] = 8'h45; tbl[16'h0FE7] = 8'h67;
    idle_cycles(2);
    test_reset();
    rst_ni = 1'b1;
    idle_cycles(2);
    test_reset();
    test_strobe_only();
    run_irq(3'd0, 1'b0, 1'b0, 16'hFFF2, 16'h1234, 1'b0, "std src0");
    test_masked();
    do_rti();
    run_irq(3'd3, 1'b0, 1'b0, 16'hFFEC, 16'hABCD, 1'b0, "std src3");
    do_rti();
    run_irq(3'd0, 1'b1, 1'b0, 16'h0FF2, 16'h0800, 1'b0, "alt src0");
    do_rti();
    run_irq(3'd2, 1'b1, 1'b0, 16'h0FEE, 16'h0000, 1'b1, "alt src2 empty");
    do_rti();
    run_irq(3'd5, 1'b0, 1'b0, 16'hFFE8, 16'h0000, 1'b0, "std src5 zero");
    do_rti();
    run_irq(3'd6, 1'b1, 1'b1, 16'h0FE6, 16'h4567, 1'b0, "alt src6 flipped");
    do_rti();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule